// File: doc/BRIEF.md
# Pseudo-Channel Commit Scheduler

This block times burst accesses onto a set of memory pseudo-channels. Each request carries a byte address and a direction (read or write). The block picks the target channel from a field of address bits. It then works out the cycle in which that channel can begin the burst and the cycle in which the burst ends. Time comes from a free-running cycle counter inside the block, and that counter is exported so a caller can relate results to the present.

Each channel keeps two pieces of state: the earliest cycle at which it is free, and the direction of its last commit. Reads and writes share this one availability slot. A channel whose direction flips can pay an optional extra delay.

The block accepts at most one request per cycle through a valid/ready handshake. It returns the result one cycle later and updates the chosen channel's state in the same step. The channel count, the burst size, the per-burst occupancy and the switch penalty are all parameters. Bank, row and refresh effects are not modelled, and requests are not reordered.

Top module: `pcs_commit_sched`

## Requirements
- R1: The channel index is (address >> log2(BURST_BYTES)) & (NUM_CH-1). With 256-byte bursts and 8 channels, address bits [10:8] are the index and bits [7:0] never affect it.
- R2: The start cycle is the later of the counter value in the accept cycle and the channel's earliest-free cycle, plus the switch penalty when one applies.
- R3: The finish cycle equals the start cycle plus OCC_CYC.
- R4: After reset every channel is free at cycle 0 and has no recorded direction, so the first request to a channel starts at the accept time with no penalty.
- R5: A request whose direction matches the channel's last direction pays no penalty.
- R6: A request whose direction differs from the channel's recorded last direction pays SWITCH_PEN extra cycles.
- R7: A read issued to a channel before a pending write on that channel finishes starts exactly at that write's finish plus SWITCH_PEN. Reads and writes share one slot per channel.
- R8: rsp_valid is high in exactly the cycle after an accepted request, and the response fields belong to that request.
- R9: Commits to one channel do not change the start time computed for any other channel.
- R10: time_o is 0 in the first cycle after reset and rises by one every cycle.
- R11: req_ready is low during reset and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address of the burst |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result of last accepted request |
| rsp_ch | output | CH_W | Selected channel |
| rsp_start | output | 32 | Commit start cycle |
| rsp_finish | output | 32 | Commit finish cycle |
| time_o | output | 32 | Current cycle counter |

## Verification
On every cycle, the bound checks cover four things:
- the one-cycle response timing;
- the fixed distance between finish and start;
- that no start lies before its accept time;
- the steady step of the time counter.

The bench's scenarios are the only way to show the stateful parts:
- shared read/write occupancy on one channel;
- the penalty applied only on a direction flip;
- the reset state of each channel;
- the independence of channels.

The bench compares every response against a per-channel model over directed and random request streams.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int TIME_W = 32;

    typedef logic [TIME_W-1:0] time_t;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        logic seen;
        dir_e dir;
    } last_dir_t;

    function automatic time_t later_of(input time_t a, input time_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic needs_turn(input last_dir_t last, input dir_e d);
        return last.seen && (last.dir != d);
    endfunction
endpackage

// File: rtl/pcs_ch_select.sv
module pcs_ch_select #(
    parameter int ADDR_W      = 40,
    parameter int NUM_CH      = 8,
    parameter int BURST_BYTES = 256,
    parameter int CH_W        = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch
);
    localparam int SHIFT = $clog2(BURST_BYTES);

    logic [ADDR_W-1:0] shifted;
    assign shifted = addr >> SHIFT;

    generate
        if (NUM_CH > 1) begin : g_multi
            assign ch = shifted[CH_W-1:0];
        end else begin : g_single
            logic unused_bits;
            assign unused_bits = ^shifted;
            assign ch = '0;
        end
    endgenerate
endmodule

// File: rtl/pcs_ch_state.sv
module pcs_ch_state
    import pcs_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [CH_W-1:0] rd_ch,
    output time_t     rd_avail,
    output last_dir_t rd_last,
    input  logic      wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  time_t     wr_finish,
    input  dir_e      wr_dir
);
    time_t     avail_q [NUM_CH];
    last_dir_t last_q  [NUM_CH];

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    avail_q[i] <= '0;
                    last_q[i]  <= '{seen: 1'b0, dir: DIR_RD};
                end else if (wr_en && (wr_ch == CH_W'(i))) begin
                    avail_q[i] <= wr_finish;
                    last_q[i]  <= '{seen: 1'b1, dir: wr_dir};
                end
            end
        end
    endgenerate

    always_comb begin
        rd_avail = avail_q[rd_ch];
        rd_last  = last_q[rd_ch];
    end
endmodule

// File: rtl/pcs_commit_calc.sv
module pcs_commit_calc
    import pcs_pkg::*;
#(
    parameter int OCC_CYC    = 8,
    parameter int SWITCH_PEN = 0
) (
    input  time_t     now,
    input  time_t     avail,
    input  last_dir_t last,
    input  dir_e      dir,
    output time_t     start,
    output time_t     finish
);
    time_t base;
    time_t pen;

    always_comb begin
        base   = later_of(now, avail);
        pen    = needs_turn(last, dir) ? TIME_W'(SWITCH_PEN) : '0;
        start  = base + pen;
        finish = start + TIME_W'(OCC_CYC);
    end
endmodule

// File: rtl/pcs_commit_sched.sv
module pcs_commit_sched
    import pcs_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int NUM_CH      = 8,
    parameter int BURST_BYTES = 256,
    parameter int OCC_CYC     = 8,
    parameter int SWITCH_PEN  = 0,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [CH_W-1:0]   rsp_ch,
    output logic [TIME_W-1:0] rsp_start,
    output logic [TIME_W-1:0] rsp_finish,
    output logic [TIME_W-1:0] time_o
);
    time_t           now_q;
    logic            accept;
    dir_e            dir;
    logic [CH_W-1:0] ch;
    time_t           avail;
    last_dir_t       last;
    time_t           start;
    time_t           finish;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;
    assign dir       = req_write ? DIR_WR : DIR_RD;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    pcs_ch_select #(
        .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BURST_BYTES(BURST_BYTES), .CH_W(CH_W)
    ) sel_i (
        .addr(req_addr),
        .ch  (ch)
    );

    pcs_ch_state #(.NUM_CH(NUM_CH), .CH_W(CH_W)) state_i (
        .clk      (clk),
        .rst      (rst),
        .rd_ch    (ch),
        .rd_avail (avail),
        .rd_last  (last),
        .wr_en    (accept),
        .wr_ch    (ch),
        .wr_finish(finish),
        .wr_dir   (dir)
    );

    pcs_commit_calc #(.OCC_CYC(OCC_CYC), .SWITCH_PEN(SWITCH_PEN)) calc_i (
        .now   (now_q),
        .avail (avail),
        .last  (last),
        .dir   (dir),
        .start (start),
        .finish(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_ch     <= '0;
            rsp_start  <= '0;
            rsp_finish <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_ch     <= ch;
                rsp_start  <= start;
                rsp_finish <= finish;
            end
        end
    end

    assign time_o = now_q;
endmodule

// File: rtl/pcs_commit_sched_chk.sv
module pcs_commit_sched_chk #(
    parameter int OCC_CYC = 8,
    parameter int CH_W    = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [CH_W-1:0] rsp_ch,
    input logic [31:0]     rsp_start,
    input logic [31:0]     rsp_finish,
    input logic [31:0]     time_o
);
    logic unused_ch;
    assign unused_ch = ^rsp_ch;

    // R8
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));

    // R3
    finish_span_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_finish == rsp_start + 32'(OCC_CYC)));

    // R2
    start_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_start >= $past(time_o)));

    // R10
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (time_o == $past(time_o) + 32'd1));
endmodule

bind pcs_commit_sched pcs_commit_sched_chk #(.OCC_CYC(OCC_CYC), .CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ch    (rsp_ch),
    .rsp_start (rsp_start),
    .rsp_finish(rsp_finish),
    .time_o    (time_o)
);

// File: tb/pcs_commit_sched_tb.sv
module pcs_commit_sched_tb_top;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 40;
    localparam int NCH    = 8;
    localparam int BURST  = 256;
    localparam int OCC    = 8;
    localparam int PEN    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid;
    logic [2:0]        rsp_ch;
    logic [31:0]       rsp_start, rsp_finish, time_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    pcs_commit_sched #(
        .ADDR_W(ADDR_W), .NUM_CH(NCH), .BURST_BYTES(BURST),
        .OCC_CYC(OCC), .SWITCH_PEN(PEN)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_ch(rsp_ch), .rsp_start(rsp_start), .rsp_finish(rsp_finish),
        .time_o(time_o)
    );

    // bench time model
    longint tcount = 0;
    always @(posedge clk) tcount <= rst ? 0 : tcount + 1;

    // per-channel reference state
    longint m_avail [NCH];
    bit     m_seen  [NCH];
    bit     m_wr    [NCH];

    bit     pend = 0;
    int     e_ch;
    longint e_s, e_f;
    string  e_tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ch_of(input logic [ADDR_W-1:0] a);
        return int'((a >> $clog2(BURST)) & (NCH - 1));
    endfunction

    function automatic longint max2(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_avail[i] = 0; m_seen[i] = 0; m_wr[i] = 0;
        end
    endtask

    // one cycle: check previous response, then drive new request
    task automatic step(input bit v, input logic [ADDR_W-1:0] a, input bit w,
                        input string stag);
        @(negedge clk);
        chk(rsp_valid === pend, "R8", "rsp_valid", longint'(rsp_valid), longint'(pend));
        if (pend && rsp_valid === 1'b1) begin
            chk(int'(rsp_ch) == e_ch, "R1", "channel", longint'(rsp_ch), longint'(e_ch));
            chk(longint'(rsp_start) == e_s, e_tag, "start", longint'(rsp_start), e_s);
            chk(longint'(rsp_finish) == e_f, "R3", "finish", longint'(rsp_finish), e_f);
        end
        chk(longint'(time_o) == tcount, "R10", "time", longint'(time_o), tcount);
        req_valid = v; req_addr = a; req_write = w;
        pend = v;
        if (v) begin
            int c;
            longint pen;
            c   = ch_of(a);
            pen = (m_seen[c] && (m_wr[c] != w)) ? PEN : 0;
            e_ch  = c;
            e_s   = max2(tcount, m_avail[c]) + pen;
            e_f   = e_s + OCC;
            e_tag = stag;
            m_avail[c] = e_f; m_seen[c] = 1; m_wr[c] = w;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b0, "R11", "ready in reset", longint'(req_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R11", "ready after reset", longint'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R8", "no rsp after reset", longint'(rsp_valid), 0);
        chk(time_o == 32'd1, "R10", "time one cycle out of reset", longint'(time_o), 1);

        // R4: fresh channels start at accept time, no penalty even for write
        step(1, 40'h00_0000_0200, 1, "R4");    // ch2 write
        // R7: read right behind write on same channel (ch2, low bits ignored)
        step(1, 40'h00_0000_02FF, 0, "R7");
        // R9: other channel unaffected
        step(1, 40'h00_0000_0300, 0, "R9");    // ch3 fresh read
        // R5: same direction back to back on ch5
        step(1, 40'h00_0000_0500, 1, "R4");
        step(1, 40'h12_3400_0D00, 1, "R5");    // ch5 again, high bits ignored
        // R6: flip on ch5
        step(1, 40'h00_0000_0580, 0, "R6");
        // R1: channel wraps above bit 10
        step(1, 40'h00_0000_0800, 0, "R1");    // ch0
        step(0, '0, 0, "R2");
        // idle long enough so channels are free in the past
        repeat (40) step(0, '0, 0, "R2");
        step(1, 40'h00_0000_0200, 0, "R2");    // ch2 read, same dir as last (R5)
        step(1, 40'h00_0000_0200, 1, "R6");    // flip

        // constrained random
        for (int n = 0; n < 2000; n++) begin
            logic [ADDR_W-1:0] a;
            bit v, w;
            a = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 0) a[10:8] = 3'($urandom_range(0, 1));
            v = ($urandom_range(0, 3) != 0);
            w = $urandom_range(0, 1);
            step(v, a, w, "R2");
            if ($urandom_range(0, 99) == 0) repeat (20) step(0, '0, 0, "R2");
        end
        step(0, '0, 0, "R2");
        step(0, '0, 0, "R2");

        // reset mid-run: channel state cleared
        @(negedge clk);
        rst = 1'b1; pend = 0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        step(1, 40'h00_0000_0700, 1, "R4");
        step(1, 40'h00_0000_0600, 0, "R4");
        step(0, '0, 0, "R2");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule